// File: doc/BRIEF.md
# Residue-Checked Multiply-Accumulate Cell

This cell is one element of a systolic array. Each cycle it takes two operands and a partial result from its neighbours. It passes both operands on unchanged and produces the partial result plus the product of the operands. The cell checks itself while it runs. A shadow datapath repeats the same multiply-add in residue form, once for each of two fixed, coprime moduli that are not powers of two. A checker reduces the binary result to those same residues and subtracts the shadow residues to form a syndrome. Any non-zero syndrome component raises an error flag.

The binary result is never rebuilt from residues, and checking never delays it. The result appears one cycle after the inputs are sampled. The error flag follows one cycle later, and only for samples marked valid. For tests, a fault-injection mask is XORed into the binary product. The checker reduces the full sum including its carry bit, so a sum that wraps the accumulator width is not reported as a fault. The checker cannot see a corruption that moves the sum by a multiple of both moduli. With the default moduli 15 and 31, that multiple is 465.

Top module: `mac_res_cell`

## Requirements
- R1: `a_out` and `b_out` equal the `a_in` and `b_in` sampled at the previous rising clock edge.
- R2: With `fault_mask` zero, `c_out` equals (`c_in` + `a_in`*`b_in`) modulo 2^16, one cycle after sampling.
- R3: While `rst_n` is low at a clock edge, every output is cleared to zero.
- R4: A valid sample whose corrupted sum differs from the true sum by an amount that is not a multiple of 15 drives `err_out` high two cycles after sampling.
- R5: A valid sample with `fault_mask` zero leaves `err_out` low two cycles later, including when the sum exceeds 16 bits.
- R6: A sample with `valid_in` low leaves `err_out` low two cycles later, whatever the mask.
- R7: A non-zero mask makes `c_out` equal `c_in` + (`a_in`*`b_in` XOR `fault_mask`) modulo 2^16, and the operands are still forwarded unchanged.
- R8: A corruption of exactly +15, which is invisible modulo 15, is still flagged through the modulus-31 check two cycles after sampling.
- R9: A corruption of exactly +465, a multiple of both moduli, leaves `err_out` low. This is the stated blind spot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Marks the sample as one to be checked |
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand |
| c_in | input | 16 | Incoming partial result |
| fault_mask | input | 16 | Test mask XORed into the binary product |
| a_out | output | 8 | Forwarded first operand |
| b_out | output | 8 | Forwarded second operand |
| c_out | output | 16 | Partial result plus product |
| err_out | output | 1 | Residue mismatch flag for the sample two cycles back |

## Verification
Forwarded operands and `c_out` are due one cycle after the sampling edge. `err_out` is due two cycles after it. Each scenario task drives its inputs on a falling edge and reads the data outputs on the next falling edge. It then drives an idle, unmasked sample and reads the flag one falling edge later, so each read sits half a cycle after the edge that updated the output. The expected flag comes from the bench's own arithmetic: the difference between the corrupted and the true sum is reduced by each modulus.

// File: rtl/mac_res_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the residue-checked MAC cell.
// Assumes moduli are small positive constants known at elaboration.
package mac_res_pkg;
    // Residue register width needed for a modulus.
    function automatic int res_bits(input int m);
        return $clog2(m);
    endfunction

    // True when the value is a power of two (forbidden as a modulus).
    function automatic bit is_pow2(input int m);
        return (m > 0) && ((m & (m - 1)) == 0);
    endfunction

    // Greatest common divisor, used to confirm coprime moduli.
    function automatic int gcd(input int x, input int y);
        int p;
        int q;
        int t;
        p = x;
        q = y;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction
endpackage

// File: rtl/mac_res_reduce.sv
`timescale 1ns/1ps
// Module: binary-to-residue converter.
// Reduces an unsigned binary word modulo a constant. Purely combinational.
// Assumes MOD is not a power of two and RES_W can hold MOD-1.
module mac_res_reduce #(
    parameter int IN_W  = 16,
    parameter int MOD   = 15,
    parameter int RES_W = 4
) (
    input  logic [IN_W-1:0]  din,
    output logic [RES_W-1:0] res
);
    // Constant modulo of the zero-extended word.
    always_comb begin
        res = RES_W'(32'(din) % MOD);
    end
endmodule

// File: rtl/mac_res_modmac.sv
`timescale 1ns/1ps
// Module: modular multiply-add unit of the shadow datapath.
// Registers (rc + ra*rb) mod MOD each cycle; inputs must already be residues.
module mac_res_modmac #(
    parameter int MOD   = 15,
    parameter int RES_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] ra,
    input  logic [RES_W-1:0] rb,
    input  logic [RES_W-1:0] rc,
    output logic [RES_W-1:0] rq
);
    localparam int WIDE_W = 2 * RES_W + 1;

    logic [WIDE_W-1:0] wide;
    logic [RES_W-1:0]  next_r;

    // Full-width modular sum before reduction.
    always_comb begin
        wide   = WIDE_W'(ra) * WIDE_W'(rb) + WIDE_W'(rc);
        next_r = RES_W'(32'(wide) % MOD);
    end

    // Shadow residue register, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rq <= '0;
        else        rq <= next_r;
    end

    // R2 support: the shadow residue always stays inside the modulus range.
    p_shadow_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rq) < MOD);
endmodule

// File: rtl/mac_res_syndrome.sv
`timescale 1ns/1ps
// Module: syndrome generator for one modulus.
// Forms (binary residue - shadow residue) mod MOD and flags a non-zero value.
// Assumes both inputs are already reduced below MOD.
module mac_res_syndrome #(
    parameter int MOD   = 15,
    parameter int RES_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] bin_res,
    input  logic [RES_W-1:0] shd_res,
    output logic [RES_W-1:0] syn,
    output logic             nz
);
    // Modular difference without a negative intermediate.
    always_comb begin
        syn = RES_W'((32'(bin_res) + MOD - 32'(shd_res)) % MOD);
        nz  = (syn != '0);
    end

    // R4 support: a zero syndrome means both residues agree.
    p_syn_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !nz |-> (bin_res == shd_res));
endmodule

// File: rtl/mac_res_cell.sv
`timescale 1ns/1ps
// Module: residue-checked multiply-accumulate cell (top).
// Forwards both operands, outputs c_in + a*b one cycle later, and flags a
// residue mismatch for valid samples one cycle after that. The checker
// reduces the full sum including its carry bit, so accumulator wrap is not
// mistaken for a fault. Assumes 2*OP_W <= ACC_W and that MOD0 and MOD1 are
// coprime and not powers of two.
module mac_res_cell #(
    parameter int OP_W  = 8,
    parameter int ACC_W = 16,
    parameter int MOD0  = 15,
    parameter int MOD1  = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [OP_W-1:0]  a_in,
    input  logic [OP_W-1:0]  b_in,
    input  logic [ACC_W-1:0] c_in,
    input  logic [ACC_W-1:0] fault_mask,
    output logic [OP_W-1:0]  a_out,
    output logic [OP_W-1:0]  b_out,
    output logic [ACC_W-1:0] c_out,
    output logic             err_out
);
    import mac_res_pkg::*;

    localparam int SUM_W = ACC_W + 1;
    localparam int NMOD  = 2;

    logic [ACC_W-1:0] prod_f;
    logic [SUM_W-1:0] sum_d;
    logic [SUM_W-1:0] sum_q;
    logic             vld_q;
    logic [NMOD-1:0]  nz;

    // Binary product with the test mask applied, then the full-width sum.
    always_comb begin
        prod_f = (ACC_W'(a_in) * ACC_W'(b_in)) ^ fault_mask;
        sum_d  = SUM_W'(c_in) + SUM_W'(prod_f);
    end

    // Binary datapath registers: operands, sum with carry, valid tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_out <= '0;
            b_out <= '0;
            sum_q <= '0;
            vld_q <= 1'b0;
        end else begin
            a_out <= a_in;
            b_out <= b_in;
            sum_q <= sum_d;
            vld_q <= valid_in;
        end
    end

    assign c_out = sum_q[ACC_W-1:0];

    // One shadow path and one checker per modulus.
    for (genvar g = 0; g < NMOD; g++) begin : g_mod
        localparam int M  = (g == 0) ? MOD0 : MOD1;
        localparam int RW = res_bits(M);

        logic [RW-1:0] ra;
        logic [RW-1:0] rb;
        logic [RW-1:0] rc;
        logic [RW-1:0] shd;
        logic [RW-1:0] bres;
        logic [RW-1:0] syn;

        mac_res_reduce #(.IN_W(OP_W), .MOD(M), .RES_W(RW)) i_red_a (
            .din(a_in), .res(ra));
        mac_res_reduce #(.IN_W(OP_W), .MOD(M), .RES_W(RW)) i_red_b (
            .din(b_in), .res(rb));
        mac_res_reduce #(.IN_W(ACC_W), .MOD(M), .RES_W(RW)) i_red_c (
            .din(c_in), .res(rc));
        mac_res_modmac #(.MOD(M), .RES_W(RW)) i_mac (
            .clk(clk), .rst_n(rst_n), .ra(ra), .rb(rb), .rc(rc), .rq(shd));
        mac_res_reduce #(.IN_W(SUM_W), .MOD(M), .RES_W(RW)) i_red_out (
            .din(sum_q), .res(bres));
        mac_res_syndrome #(.MOD(M), .RES_W(RW)) i_syn (
            .clk(clk), .rst_n(rst_n), .bin_res(bres), .shd_res(shd),
            .syn(syn), .nz(nz[g]));
    end

    // Error flag register, qualified by the delayed valid tag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_out <= 1'b0;
        else        err_out <= vld_q && (|nz);
    end

    // R1: operands are forwarded unchanged one cycle later.
    p_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (a_out == $past(a_in)) && (b_out == $past(b_in)));

    // R2: unmasked samples give the plain multiply-add.
    p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(fault_mask) == '0)) |->
        (c_out == ACC_W'($past(c_in) + ACC_W'($past(a_in)) * ACC_W'($past(b_in)))));

    // R5: clean valid samples never raise the flag.
    p_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && ($past(fault_mask, 2) == '0)) |-> !err_out);

    // R6: samples not marked valid never raise the flag.
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && !$past(valid_in, 2)) |-> !err_out);
endmodule

// File: tb/test_mac_res_cell.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the residue-checked MAC cell.
module test_mac_res_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic [15:0] c_in = '0;
    logic [15:0] fault_mask = '0;
    logic [7:0]  a_out;
    logic [7:0]  b_out;
    logic [15:0] c_out;
    logic        err_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mac_res_cell i_mac_res_cell (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
        .c_in(c_in), .fault_mask(fault_mask), .a_out(a_out), .b_out(b_out),
        .c_out(c_out), .err_out(err_out));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample, check the data one cycle later and the flag two cycles later.
    task automatic run_sample(input int a, input int b, input int c, input int mask,
                              input bit v, input string req);
        int true_sum;
        int bad_sum;
        int diff;
        int exp_c;
        bit exp_e;
        true_sum = c + a * b;
        bad_sum  = c + ((a * b) ^ mask);
        diff     = bad_sum - true_sum;
        exp_c    = bad_sum % 65536;
        exp_e    = v && ((diff % 15 != 0) || (diff % 31 != 0));
        @(negedge clk);
        a_in = 8'(a); b_in = 8'(b); c_in = 16'(c);
        fault_mask = 16'(mask); valid_in = v;
        @(negedge clk);
        chk(a_out == 8'(a) && b_out == 8'(b), {req, " R1 forward"},
            int'({a_out, b_out}), int'({8'(a), 8'(b)}));
        chk(c_out == 16'(exp_c), {req, " c_out"}, int'(c_out), exp_c);
        valid_in = 1'b0; fault_mask = '0;
        @(negedge clk);
        chk(err_out == exp_e, {req, " err_out"}, int'(err_out), int'(exp_e));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_in = 8'hA5; b_in = 8'h5A; c_in = 16'hFFFF; valid_in = 1'b1; fault_mask = 16'h1;
        repeat (3) @(negedge clk);
        chk(a_out == 0 && b_out == 0 && c_out == 0 && err_out == 0, "R3 reset",
            int'(c_out) + int'(err_out), 0);
        valid_in = 1'b0; fault_mask = '0;
        rst_n = 1'b1;
    endtask

    task automatic t_plain();
        run_sample(3, 7, 100, 0, 1'b1, "R2 small");
        run_sample(255, 1, 0, 0, 1'b1, "R2 unit");
        run_sample(17, 200, 1234, 0, 1'b1, "R2 mixed");
        run_sample(0, 0, 0, 0, 1'b1, "R5 zero");
    endtask

    task automatic t_wrap();
        run_sample(255, 255, 65535, 0, 1'b1, "R5 wrap");
        run_sample(200, 200, 30000, 0, 1'b1, "R5 wrap2");
    endtask

    task automatic t_fault();
        run_sample(3, 7, 100, 1, 1'b1, "R4 R7 mask1");
        run_sample(12, 34, 500, 16'h0100, 1'b1, "R4 R7 mask256");
    endtask

    task automatic t_one_mod();
        run_sample(0, 9, 40, 15, 1'b1, "R8 plus15");
    endtask

    task automatic t_blind();
        run_sample(0, 9, 40, 465, 1'b1, "R9 plus465");
    endtask

    task automatic t_invalid();
        run_sample(3, 7, 100, 1, 1'b0, "R6 invalid");
    endtask

    initial begin
        t_reset();
        t_plain();
        t_wrap();
        t_fault();
        t_one_mod();
        t_blind();
        t_invalid();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule